// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block is a full-duplex synchronous serial port that acts as the clock master. Every frame moves one 8-bit byte out on a transmit data pin and takes one byte in from a receive data pin, least significant bit first. Both directions run on a serial clock that the block makes itself, by dividing the system clock with a fixed parameter. The serial clock idles high and toggles only while a frame is in progress.

Software talks to the port through four byte-wide registers: a control register, a transmit holding register, a receive data register and a status register. The status register holds three flags: transmit-empty, receive-full and overrun. The transmit-empty flag rising raises a one-cycle transmit request, and the receive-full flag rising raises a one-cycle receive request. A DMA agent can answer these requests through dedicated strobes, which move the data and clear the matching flag without any status-register traffic. If a byte arrives while the previous one is still unread, the port latches an overrun and stops exchanging frames until software clears it.

Register map (address, content): 0 control (bit 0 transmit enable, bit 1 receive enable); 1 transmit holding byte; 2 receive data byte; 3 status (bit 0 transmit-empty, bit 1 receive-full, bit 2 overrun).

Top module: `sync_serial_port`

## Requirements
- R1: After reset the serial clock and transmit pin are high, status reads 0x01 (only transmit-empty set), control reads 0, and both request outputs are low.
- R2: A frame shifts 8 bits LSB first. The serial clock falls, then rises, 8 times, and each half period lasts HALF_DIV system clocks. The transmit pin changes only on a falling serial-clock edge. The receive pin is sampled on the rising edge. The clock is high whenever no frame is running.
- R3: At the start of a frame the holding byte moves into the shifter and transmit-empty becomes 1. Every 0-to-1 change of transmit-empty gives exactly one single-cycle pulse on tx_irq.
- R4: When a frame ends with receive-full at 0, the received byte goes into the receive data register and receive-full becomes 1. Each such rise gives one single-cycle pulse on rx_irq.
- R5: A frame starts only when full duplex is active, transmit-empty is 0 and overrun is 0. A byte loaded and a byte read during the current frame let the next frame follow with no software start.
- R6: A frame that ends while receive-full is 1 sets overrun (status bit 2). The new byte is discarded and the receive data register keeps its old value. No frame starts while overrun is 1, and clearing overrun lets frames resume.
- R7: Writing 0 to a status bit clears that flag only if the status register was read with that flag at 1 before the write. Writing 1, or writing 0 with no prior read, leaves the flag unchanged.
- R8: Full duplex starts only from a single control write of 0b11 made while both enables are 0. Setting the two enables in separate writes (0b01, then 0b11) starts no frame.
- R9: A control write with a nonzero enable field during a frame is ignored. A control write of 0 during a frame aborts it: the serial clock returns high at once and no received byte is stored.
- R10: A pulse on dma_tx_we loads dma_tx_byte into the holding register and clears transmit-empty. A pulse on dma_rx_re clears receive-full, and dma_rx_byte always shows the receive data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (arms status clearing) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| dma_tx_we | input | 1 | DMA write to the holding register, clears transmit-empty |
| dma_tx_byte | input | 8 | DMA transmit byte |
| dma_rx_re | input | 1 | DMA read of the receive register, clears receive-full |
| dma_rx_byte | output | 8 | Receive data register contents |
| tx_irq | output | 1 | Pulse when transmit-empty rises |
| rx_irq | output | 1 | Pulse when receive-full rises |
| sclk_o | output | 1 | Serial clock, idle high |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |

## Verification
The assertions check the serial-line rules on every cycle: the clock stays high between frames, the transmit pin moves only with a falling clock, and each frame opens with a falling edge. They also check that every request pulse lasts one cycle and follows a frame start (tx_irq) or a frame end (rx_irq). The rest depends on register history and on a far-end device, so only the bench scenarios show it. That covers the bit order and data on both pins, the overrun freeze and its release, the read-then-write-zero clearing rule, the enable ordering, aborts, and the flag clearing done by DMA accesses.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } ph_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_TXB  = 2'd1;
    localparam logic [1:0] A_RXB  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int F_TXE = 0;
    localparam int F_RXF = 1;
    localparam int F_OVR = 2;
    localparam int N_FLAGS = 3;

endpackage

// File: rtl/ssp_shift_engine.sv
module ssp_shift_engine
    import ssp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rxd,
    output logic              sclk,
    output logic              txd,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        ph_e               ph;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] shtx;
        logic [DATA_W-1:0] shrx;
        logic              sclk;
        logic              txd;
        logic              done;
    } eng_t;

    eng_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph   = PH_LOW;
                    st_d.cnt  = '0;
                    st_d.bitn = '0;
                    st_d.txd  = tx_byte[0];
                    st_d.shtx = tx_byte >> 1;
                    st_d.sclk = 1'b0;
                end
            end
            PH_LOW: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.cnt  = '0;
                    st_d.sclk = 1'b1;
                    st_d.shrx = {rxd, st_q.shrx[DATA_W-1:1]};
                    st_d.ph   = PH_HIGH;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.cnt = '0;
                    if (st_q.bitn == BIT_LAST) begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.bitn = st_q.bitn + 1'b1;
                        st_d.sclk = 1'b0;
                        st_d.txd  = st_q.shtx[0];
                        st_d.shtx = st_q.shtx >> 1;
                        st_d.ph   = PH_LOW;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
        if (abort) begin
            st_d.ph   = PH_IDLE;
            st_d.cnt  = '0;
            st_d.sclk = 1'b1;
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.sclk <= 1'b1;
            st_q.txd  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk    = st_q.sclk;
    assign txd     = st_q.txd;
    assign busy    = (st_q.ph != PH_IDLE);
    assign done    = st_q.done;
    assign rx_byte = st_q.shrx;

endmodule

// File: rtl/ssp_host_regs.sv
module ssp_host_regs
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dma_tx_we,
    input  logic [DATA_W-1:0] dma_tx_byte,
    input  logic              dma_rx_re,
    output logic [DATA_W-1:0] dma_rx_byte,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx_byte,
    output logic              eng_start,
    output logic              eng_abort,
    output logic [DATA_W-1:0] tx_hold,
    output logic              tx_irq,
    output logic              rx_irq
);

    typedef struct packed {
        logic [1:0]         en;
        logic               duplex;
        logic [DATA_W-1:0]  tdr;
        logic [DATA_W-1:0]  rdr;
        logic [N_FLAGS-1:0] flg;
        logic [N_FLAGS-1:0] seen;
        logic               tx_irq;
        logic               rx_irq;
    } reg_t;

    reg_t r_q, r_d;

    logic wr_ctrl, wr_txb, wr_stat, rd_stat;

    always_comb begin
        wr_ctrl = host_wr && (host_addr == A_CTRL);
        wr_txb  = host_wr && (host_addr == A_TXB);
        wr_stat = host_wr && (host_addr == A_STAT);
        rd_stat = host_rd && (host_addr == A_STAT);

        eng_abort = wr_ctrl && (host_wdata[1:0] == 2'b00);
        eng_start = r_q.duplex && !r_q.flg[F_TXE] && !r_q.flg[F_OVR]
                    && !eng_busy && !eng_done && !eng_abort;

        r_d = r_q;

        // control: locked during a frame except for the stop write
        if (wr_ctrl && (!eng_busy || eng_abort)) begin
            r_d.en     = host_wdata[1:0];
            r_d.duplex = (host_wdata[1:0] == 2'b11) &&
                         (r_q.duplex || (r_q.en == 2'b00));
        end

        // holding register
        if (dma_tx_we) begin
            r_d.tdr        = dma_tx_byte;
            r_d.flg[F_TXE] = 1'b0;
        end else if (wr_txb) begin
            r_d.tdr = host_wdata;
        end

        // read-then-write-zero clearing
        if (wr_stat) begin
            for (int i = 0; i < N_FLAGS; i++) begin
                if (!host_wdata[i] && r_q.seen[i]) begin
                    r_d.flg[i] = 1'b0;
                end
            end
        end

        if (dma_rx_re) begin
            r_d.flg[F_RXF] = 1'b0;
        end

        // hardware set events dominate clears in the same cycle
        if (eng_start) begin
            r_d.flg[F_TXE] = 1'b1;
        end

        if (eng_done) begin
            if (r_q.flg[F_RXF]) begin
                r_d.flg[F_OVR] = 1'b1;
            end else begin
                r_d.rdr        = eng_rx_byte;
                r_d.flg[F_RXF] = 1'b1;
            end
        end

        for (int i = 0; i < N_FLAGS; i++) begin
            r_d.seen[i] = r_d.flg[i] && (r_q.seen[i] || (rd_stat && r_q.flg[i]));
        end

        r_d.tx_irq = r_d.flg[F_TXE] && !r_q.flg[F_TXE];
        r_d.rx_irq = r_d.flg[F_RXF] && !r_q.flg[F_RXF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.flg[F_TXE] <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (host_addr)
            A_CTRL:  host_rdata = {{(DATA_W-2){1'b0}}, r_q.en};
            A_TXB:   host_rdata = r_q.tdr;
            A_RXB:   host_rdata = r_q.rdr;
            default: host_rdata = {{(DATA_W-N_FLAGS){1'b0}}, r_q.flg};
        endcase
    end

    assign dma_rx_byte = r_q.rdr;
    assign tx_hold     = r_q.tdr;
    assign tx_irq      = r_q.tx_irq;
    assign rx_irq      = r_q.rx_irq;

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dma_tx_we,
    input  logic [DATA_W-1:0] dma_tx_byte,
    input  logic              dma_rx_re,
    output logic [DATA_W-1:0] dma_rx_byte,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              sclk_o,
    output logic              txd_o,
    input  logic              rxd_i
);

    logic              eng_start;
    logic              eng_abort;
    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rx_byte;
    logic [DATA_W-1:0] tx_hold;

    ssp_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .dma_tx_we   (dma_tx_we),
        .dma_tx_byte (dma_tx_byte),
        .dma_rx_re   (dma_rx_re),
        .dma_rx_byte (dma_rx_byte),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .eng_rx_byte (eng_rx_byte),
        .eng_start   (eng_start),
        .eng_abort   (eng_abort),
        .tx_hold     (tx_hold),
        .tx_irq      (tx_irq),
        .rx_irq      (rx_irq)
    );

    ssp_shift_engine #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .abort   (eng_abort),
        .tx_byte (tx_hold),
        .rxd     (rxd_i),
        .sclk    (sclk_o),
        .txd     (txd_o),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_byte (eng_rx_byte)
    );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic txd_o,
    input logic tx_irq,
    input logic rx_irq,
    input logic eng_start,
    input logic eng_done,
    input logic eng_busy
);

    p_sclk_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> sclk_o);

    p_txd_moves_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_o != $past(txd_o)) |-> $fell(sclk_o));

    p_start_drops_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !sclk_o);

    p_txirq_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(eng_start));

    p_txirq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_rxirq_from_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(eng_done));

    p_rxirq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

endmodule

bind sync_serial_port ssp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_o    (sclk_o),
    .txd_o     (txd_o),
    .tx_irq    (tx_irq),
    .rx_irq    (rx_irq),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_busy  (eng_busy)
);

// File: tb/test_sync_serial_port.sv
`timescale 1ns/1ps
module test_sync_serial_port;

    localparam int HALF  = 4;
    localparam int FRAME = 16 * HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       dma_tx_we = 1'b0;
    logic [7:0] dma_tx_byte = '0;
    logic       dma_rx_re = 1'b0;
    logic [7:0] dma_rx_byte;
    logic       tx_irq, rx_irq, sclk_o, txd_o;
    logic       rxd_i = 1'b0;

    int total = 0;
    int bad = 0;

    sync_serial_port #(.DATA_W(8), .HALF_DIV(HALF)) i_sync_serial_port (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dma_tx_we(dma_tx_we), .dma_tx_byte(dma_tx_byte), .dma_rx_re(dma_rx_re),
        .dma_rx_byte(dma_rx_byte), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .sclk_o(sclk_o), .txd_o(txd_o), .rxd_i(rxd_i)
    );

    always #10 clk = ~clk;

    // far-end device model
    logic [7:0] pat [0:3];
    logic [7:0] got [0:3];
    logic [7:0] s_shift = '0;
    logic [2:0] s_bit;
    logic [7:0] frames_seen;
    int         rises_total;
    int         low_cnt, txirq_cnt, rxirq_cnt;

    always @(negedge sclk_o) rxd_i <= pat[frames_seen[1:0]][s_bit];

    always @(posedge sclk_o or negedge rst_n) begin
        if (!rst_n) begin
            s_bit <= '0;
            frames_seen <= '0;
            rises_total <= 0;
        end else begin
            s_shift <= {txd_o, s_shift[7:1]};
            rises_total <= rises_total + 1;
            if (s_bit == 3'd7) begin
                got[frames_seen[1:0]] <= {txd_o, s_shift[7:1]};
                frames_seen <= frames_seen + 1'b1;
            end
            s_bit <= s_bit + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= 0; txirq_cnt <= 0; rxirq_cnt <= 0;
        end else begin
            if (!sclk_o) low_cnt <= low_cnt + 1;
            if (tx_irq) txirq_cnt <= txirq_cnt + 1;
            if (rx_irq) rxirq_cnt <= rxirq_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; host_wr = 0; host_rd = 0; dma_tx_we = 0; dma_rx_re = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #2 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic clear_flag(input int idx);
        logic [7:0] d;
        host_read(2'd3, d);
        host_write(2'd3, 8'hFF ^ (8'h01 << idx));
    endtask

    task automatic load_tx(input logic [7:0] b);
        host_write(2'd1, b);
        clear_flag(0);
    endtask

    task automatic go_duplex();
        host_write(2'd0, 8'h00);
        host_write(2'd0, 8'h03);
    endtask

    task automatic wait_frames(input int n);
        wait (frames_seen == n[7:0]);
        repeat (HALF + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        apply_reset();
        check("R1 sclk", sclk_o, 1);
        check("R1 txd", txd_o, 1);
        check("R1 irqs", {tx_irq, rx_irq}, 0);
        host_read(2'd3, d); check("R1 status", d, 8'h01);
        host_read(2'd0, d); check("R1 ctrl", d, 8'h00);
    endtask

    task automatic t_single_frame();
        logic [7:0] d;
        apply_reset();
        pat[0] = 8'hC6;
        go_duplex();
        load_tx(8'h3C);
        wait_frames(1);
        check("R2 far end got LSB-first byte", got[0], 8'h3C);
        host_read(2'd2, d); check("R2 rx byte", d, 8'hC6);
        check("R2 half period", low_cnt, 8 * HALF);
        check("R2 sclk idle", sclk_o, 1);
        host_read(2'd3, d); check("R3 R4 status", d, 8'h03);
        check("R3 tx_irq count", txirq_cnt, 1);
        check("R4 rx_irq count", rxirq_cnt, 1);
        repeat (2 * FRAME) @(negedge clk);
        check("R5 no frame without byte", frames_seen, 1);
    endtask

    task automatic t_back_to_back();
        logic [7:0] d;
        apply_reset();
        pat[0] = 8'h81; pat[1] = 8'h7E;
        go_duplex();
        load_tx(8'hA1);
        wait (txirq_cnt == 1);
        load_tx(8'hB2);
        wait_frames(1);
        host_read(2'd2, d); check("R5 first rx", d, 8'h81);
        clear_flag(1);
        wait_frames(2);
        check("R5 second frame ran", frames_seen, 2);
        check("R5 far end bytes", {got[0], got[1]}, 16'hA1B2);
        host_read(2'd2, d); check("R5 second rx", d, 8'h7E);
        host_read(2'd3, d); check("R5 no overrun", d, 8'h03);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        apply_reset();
        pat[0] = 8'h11; pat[1] = 8'h22; pat[2] = 8'h33;
        go_duplex();
        load_tx(8'hE1);
        wait_frames(1);
        load_tx(8'hE2);
        wait_frames(2);
        host_read(2'd3, d); check("R6 overrun set", d, 8'h07);
        host_read(2'd2, d); check("R6 old byte kept", d, 8'h11);
        load_tx(8'hE3);
        repeat (3 * FRAME) @(negedge clk);
        check("R6 frozen", frames_seen, 2);
        host_read(2'd3, d); check("R6 frozen status", d, 8'h06);
        clear_flag(2);
        wait_frames(3);
        check("R6 resumed", got[2], 8'hE3);
    endtask

    task automatic t_flag_clear();
        logic [7:0] d;
        apply_reset();
        host_write(2'd3, 8'h00);
        host_read(2'd3, d); check("R7 zero without read", d, 8'h01);
        host_write(2'd3, 8'h01);
        host_read(2'd3, d); check("R7 write one", d, 8'h01);
        host_write(2'd3, 8'h00);
        host_read(2'd3, d); check("R7 read then zero", d, 8'h00);
    endtask

    task automatic t_enable_order();
        apply_reset();
        pat[0] = 8'h5C;
        load_tx(8'h77);
        host_write(2'd0, 8'h01);
        host_write(2'd0, 8'h03);
        repeat (2 * FRAME) @(negedge clk);
        check("R8 separate writes: no clock", low_cnt, 0);
        check("R8 separate writes: no frame", frames_seen, 0);
        go_duplex();
        wait_frames(1);
        check("R8 joint write starts", got[0], 8'h77);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        int r;
        apply_reset();
        pat[0] = 8'hF0;
        go_duplex();
        load_tx(8'h96);
        wait (rises_total == 3);
        host_write(2'd0, 8'h01);
        host_read(2'd0, d); check("R9 ctrl write ignored", d, 8'h03);
        host_write(2'd0, 8'h00);
        repeat (2) @(negedge clk);
        check("R9 clock high after stop", sclk_o, 1);
        r = rises_total;
        repeat (4 * FRAME) @(negedge clk);
        check("R9 no more edges", rises_total, r);
        host_read(2'd3, d); check("R9 nothing stored", d, 8'h01);
        host_read(2'd0, d); check("R9 ctrl cleared", d, 8'h00);
    endtask

    task automatic t_dma();
        logic [7:0] d;
        apply_reset();
        pat[0] = 8'h69;
        go_duplex();
        @(negedge clk); dma_tx_byte = 8'h5A; dma_tx_we = 1'b1;
        @(negedge clk); dma_tx_we = 1'b0;
        wait_frames(1);
        check("R10 dma byte sent", got[0], 8'h5A);
        check("R10 dma rx byte", dma_rx_byte, 8'h69);
        host_read(2'd3, d); check("R10 full before read", d, 8'h03);
        @(negedge clk); dma_rx_re = 1'b1;
        @(negedge clk); dma_rx_re = 1'b0;
        host_read(2'd3, d); check("R10 dma read clears", d, 8'h01);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            pat[i] = 8'h00;
            got[i] = 8'h00;
        end
        t_reset();
        t_single_frame();
        t_back_to_back();
        t_overrun();
        t_flag_clear();
        t_enable_order();
        t_abort();
        t_dma();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule